// File: doc/BRIEF.md
# Per-Destination Cell Queue Buffer

This block sits on the input side of a router line card. Its job is to keep cells waiting for the switched backplane. Each arriving cell is a fixed-size word with a destination port tag and an end-of-packet flag. The block does not hold all cells in one first-in first-out line. It keeps one logical queue for each output port, and all of those queues share one pool of cell slots. Each queue is a linked chain of slots. Unused slots sit on a free-slot ring. Because of this, a cell stalled for a busy or backpressured output never holds back cells bound for other outputs.

Toward the backplane allocator, the block presents one request bit per output. Each backplane transfer carries two cells to the same destination. So a queue asks for service only when it holds at least a pair of cells, or when it holds the final cell of a packet. A per-output inhibit line from the far side masks that request. The allocator answers with a grant naming one port. The block then removes the head cell of that queue and presents it on the output one cycle later. A grant that cannot be honoured raises an error strobe and changes nothing. An arrival that cannot be stored is discarded and counted.

Top module: `voq_buffer`

## Requirements
- R1: While reset is held and in the first cycle after it, `req`, `out_valid` and `grant_err` are 0, `drop_cnt` is 0, and every queue is empty.
- R2: Cells of one destination leave in the order they arrived. Each leaves with the data and end-of-packet flag it was written with.
- R3: `req[j]` is 1 exactly when `inhibit[j]` is 0 and queue j holds at least two cells or at least one cell with end-of-packet set. The bit follows `inhibit` in the same cycle, with no register in between.
- R4: A grant sampled at a clock edge with `grant_valid`=1 and `grant_port`=j, where queue j is non-empty and `inhibit[j]`=0, removes the head of queue j. In the following cycle it gives `out_valid`=1, `out_port`=j and that cell's `out_data`/`out_eop`. With no grant, `out_valid` is 0 in the next cycle.
- R5: A grant to an empty queue, to an inhibited queue, or to a port number of N or above gives `grant_err`=1 and `out_valid`=0 in the next cycle. It leaves every queue unchanged.
- R6: A queue that is inhibited or not granted never delays cells of any other destination. Those cells can be dequeued while it waits.
- R7: The queues share DEPTH slots in total. If DEPTH cells are stored at a clock edge (counted before that edge's dequeue), an arrival is discarded and `drop_cnt` rises by 1. The counter holds at its maximum value.
- R8: An arrival whose destination tag is N or above is discarded and counted in `drop_cnt`.
- R9: An arrival and a dequeue in the same cycle both take effect, including on the same queue. A slot freed by a dequeue is available to an arrival from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An arriving cell is present this cycle |
| in_dest | input | PORT_W | Destination port tag of the arriving cell |
| in_eop | input | 1 | Arriving cell ends its packet |
| in_data | input | CELL_W | Cell payload word |
| inhibit | input | N_PORTS | Per-output backpressure; bit j masks requests and grants for output j |
| grant_valid | input | 1 | Allocator grant present this cycle |
| grant_port | input | PORT_W | Output port whose queue is granted |
| req | output | N_PORTS | Per-output service request vector |
| out_valid | output | 1 | Dequeued cell present |
| out_port | output | PORT_W | Queue the dequeued cell came from |
| out_eop | output | 1 | End-of-packet flag of the dequeued cell |
| out_data | output | CELL_W | Payload of the dequeued cell |
| grant_err | output | 1 | The previous cycle's grant could not be honoured |
| drop_cnt | output | DROP_W | Saturating count of discarded arrivals |

## Verification
The embedded properties check several things on every cycle. The free-slot ring never underflows or overflows. The slots held by the queues plus the free slots always add up to DEPTH. No queue is popped while empty, and its end-of-packet tally never exceeds its length. An output cell only follows a grant, and an error never comes with an output cell. The drop counter never moves by more than one. Other behaviours can only be shown by the bench's scenarios against its behavioural per-destination model. These are FIFO order and data integrity per destination, the exact request rule under changing backpressure, freedom from head-of-line blocking, the drop decision at a full pool, and a same-cycle arrival and grant on one queue.

// File: rtl/voq_pkg.sv
package voq_pkg;

    typedef enum logic [1:0] {
        GK_NONE = 2'd0,
        GK_POP  = 2'd1,
        GK_ERR  = 2'd2
    } grant_kind_e;

    function automatic int width_of(input int v);
        return (v <= 2) ? 1 : $clog2(v);
    endfunction

endpackage

// File: rtl/voq_free_ring.sv
module voq_free_ring #(
    parameter int DEPTH = 32,
    parameter int IDX_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             take,
    input  logic             give,
    input  logic [IDX_W-1:0] give_idx,
    output logic [IDX_W-1:0] head_idx,
    output logic [CNT_W-1:0] free_cnt
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

    logic [IDX_W-1:0] ring [DEPTH];
    logic [IDX_W-1:0] rd_ptr, wr_ptr;

    assign head_idx = ring[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) ring[i] <= IDX_W'(i);
            rd_ptr   <= '0;
            wr_ptr   <= '0;
            free_cnt <= CNT_W'(DEPTH);
        end else begin
            if (take) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            if (give) begin
                ring[wr_ptr] <= give_idx;
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            case ({take, give})
                2'b10:   free_cnt <= free_cnt - 1'b1;
                2'b01:   free_cnt <= free_cnt + 1'b1;
                default: free_cnt <= free_cnt;
            endcase
        end
    end

    p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
        take |-> free_cnt != '0);
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
        give |-> free_cnt != CNT_W'(DEPTH));

endmodule

// File: rtl/voq_cell_store.sv
module voq_cell_store #(
    parameter int DEPTH  = 32,
    parameter int CELL_W = 32,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [CELL_W-1:0] wr_data,
    input  logic              wr_eop,
    input  logic              lk_en,
    input  logic [IDX_W-1:0]  lk_idx,
    input  logic [IDX_W-1:0]  lk_val,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CELL_W-1:0] rd_data,
    output logic              rd_eop,
    output logic [IDX_W-1:0]  rd_next
);
    logic [CELL_W-1:0] data_mem [DEPTH];
    logic              eop_mem  [DEPTH];
    logic [IDX_W-1:0]  link_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            data_mem[wr_idx] <= wr_data;
            eop_mem[wr_idx]  <= wr_eop;
        end
        if (lk_en) link_mem[lk_idx] <= lk_val;
    end

    assign rd_data = data_mem[rd_idx];
    assign rd_eop  = eop_mem[rd_idx];
    assign rd_next = link_mem[rd_idx];

endmodule

// File: rtl/voq_chain_ctrl.sv
module voq_chain_ctrl #(
    parameter int IDX_W = 5,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             push_eop,
    input  logic [IDX_W-1:0] new_idx,
    input  logic             pop,
    input  logic             pop_eop,
    input  logic [IDX_W-1:0] head_link,
    output logic [IDX_W-1:0] head,
    output logic [IDX_W-1:0] tail,
    output logic [CNT_W-1:0] len,
    output logic [CNT_W-1:0] eop_len
);
    always_ff @(posedge clk) begin
        if (rst) begin
            head    <= '0;
            tail    <= '0;
            len     <= '0;
            eop_len <= '0;
        end else begin
            case ({push, pop})
                2'b10: begin
                    if (len == '0) head <= new_idx;
                    tail <= new_idx;
                    len  <= len + 1'b1;
                end
                2'b01: begin
                    head <= head_link;
                    len  <= len - 1'b1;
                end
                2'b11: begin
                    head <= (len == CNT_W'(1)) ? new_idx : head_link;
                    tail <= new_idx;
                end
                default: ;
            endcase
            eop_len <= eop_len + CNT_W'(push && push_eop) - CNT_W'(pop && pop_eop);
        end
    end

    p_pop_nonempty_r5: assert property (@(posedge clk) disable iff (rst)
        pop |-> len != '0);
    p_eop_bounded_r3: assert property (@(posedge clk) disable iff (rst)
        eop_len <= len);

endmodule

// File: rtl/voq_buffer.sv
module voq_buffer
    import voq_pkg::*;
#(
    parameter int N_PORTS = 15,
    parameter int DEPTH   = 32,
    parameter int CELL_W  = 32,
    parameter int DROP_W  = 16,
    localparam int PORT_W = width_of(N_PORTS + 1),
    localparam int IDX_W  = width_of(DEPTH),
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [PORT_W-1:0]  in_dest,
    input  logic               in_eop,
    input  logic [CELL_W-1:0]  in_data,
    input  logic [N_PORTS-1:0] inhibit,
    input  logic               grant_valid,
    input  logic [PORT_W-1:0]  grant_port,
    output logic [N_PORTS-1:0] req,
    output logic               out_valid,
    output logic [PORT_W-1:0]  out_port,
    output logic               out_eop,
    output logic [CELL_W-1:0]  out_data,
    output logic               grant_err,
    output logic [DROP_W-1:0]  drop_cnt
);
    localparam int SUM_W = CNT_W + PORT_W + 1;

    logic [IDX_W-1:0] q_head [N_PORTS];
    logic [IDX_W-1:0] q_tail [N_PORTS];
    logic [CNT_W-1:0] q_len  [N_PORTS];
    logic [CNT_W-1:0] q_eop  [N_PORTS];

    logic [CNT_W-1:0] free_cnt;
    logic [IDX_W-1:0] alloc_idx;
    logic [IDX_W-1:0] rd_next;
    logic [CELL_W-1:0] rd_data;
    logic             rd_eop;

    logic             dest_ok, grant_ok;
    logic             do_push, do_pop;
    logic [CNT_W-1:0] g_len, p_len;
    logic [IDX_W-1:0] g_head, p_tail;
    logic             g_inh;
    grant_kind_e      gkind;
    logic [SUM_W-1:0] occ_sum;

    assign dest_ok  = ({1'b0, in_dest}    < (PORT_W+1)'(N_PORTS));
    assign grant_ok = ({1'b0, grant_port} < (PORT_W+1)'(N_PORTS));

    always_comb begin
        g_len = '0; g_head = '0; g_inh = 1'b0;
        p_len = '0; p_tail = '0;
        for (int j = 0; j < N_PORTS; j++) begin
            if (grant_port == PORT_W'(j)) begin
                g_len  = q_len[j];
                g_head = q_head[j];
                g_inh  = inhibit[j];
            end
            if (in_dest == PORT_W'(j)) begin
                p_len  = q_len[j];
                p_tail = q_tail[j];
            end
        end
    end

    assign do_push = in_valid && dest_ok && (free_cnt != '0);
    assign do_pop  = (gkind == GK_POP);

    always_comb begin
        if (!grant_valid)                               gkind = GK_NONE;
        else if (grant_ok && g_len != '0 && !g_inh)     gkind = GK_POP;
        else                                            gkind = GK_ERR;
    end

    voq_free_ring #(.DEPTH(DEPTH), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_free (
        .clk      (clk),
        .rst      (rst),
        .take     (do_push),
        .give     (do_pop),
        .give_idx (g_head),
        .head_idx (alloc_idx),
        .free_cnt (free_cnt)
    );

    voq_cell_store #(.DEPTH(DEPTH), .CELL_W(CELL_W), .IDX_W(IDX_W)) u_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_idx  (alloc_idx),
        .wr_data (in_data),
        .wr_eop  (in_eop),
        .lk_en   (do_push && p_len != '0),
        .lk_idx  (p_tail),
        .lk_val  (alloc_idx),
        .rd_idx  (g_head),
        .rd_data (rd_data),
        .rd_eop  (rd_eop),
        .rd_next (rd_next)
    );

    for (genvar j = 0; j < N_PORTS; j++) begin : g_chain
        voq_chain_ctrl #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_chain (
            .clk       (clk),
            .rst       (rst),
            .push      (do_push && in_dest == PORT_W'(j)),
            .push_eop  (in_eop),
            .new_idx   (alloc_idx),
            .pop       (do_pop && grant_port == PORT_W'(j)),
            .pop_eop   (rd_eop),
            .head_link (rd_next),
            .head      (q_head[j]),
            .tail      (q_tail[j]),
            .len       (q_len[j]),
            .eop_len   (q_eop[j])
        );
        assign req[j] = !inhibit[j] && (q_len[j] >= CNT_W'(2) || q_eop[j] != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_eop   <= 1'b0;
            out_data  <= '0;
            grant_err <= 1'b0;
            drop_cnt  <= '0;
        end else begin
            out_valid <= do_pop;
            grant_err <= (gkind == GK_ERR);
            if (do_pop) begin
                out_port <= grant_port;
                out_eop  <= rd_eop;
                out_data <= rd_data;
            end
            if (in_valid && !do_push && drop_cnt != '1)
                drop_cnt <= drop_cnt + 1'b1;
        end
    end

    always_comb begin
        occ_sum = '0;
        for (int j = 0; j < N_PORTS; j++) occ_sum = occ_sum + SUM_W'(q_len[j]);
    end

    p_slot_conserve_r7: assert property (@(posedge clk) disable iff (rst)
        occ_sum + SUM_W'(free_cnt) == SUM_W'(DEPTH));
    p_out_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(grant_valid));
    p_err_no_cell_r5: assert property (@(posedge clk) disable iff (rst)
        grant_err |-> !out_valid);
    p_drop_step_r7: assert property (@(posedge clk) disable iff (rst)
        (drop_cnt - $past(drop_cnt)) <= DROP_W'(1));

endmodule

// File: tb/voq_buffer_tb_top.sv
module voq_buffer_tb_top;
    localparam int N      = 15;
    localparam int DEPTH  = 32;
    localparam int CELL_W = 32;
    localparam int DROP_W = 16;
    localparam int PW     = 4;

    logic              clk = 1'b0;
    logic              rst;
    logic              in_valid;
    logic [PW-1:0]     in_dest;
    logic              in_eop;
    logic [CELL_W-1:0] in_data;
    logic [N-1:0]      inhibit;
    logic              grant_valid;
    logic [PW-1:0]     grant_port;
    logic [N-1:0]      req;
    logic              out_valid;
    logic [PW-1:0]     out_port;
    logic              out_eop;
    logic [CELL_W-1:0] out_data;
    logic              grant_err;
    logic [DROP_W-1:0] drop_cnt;

    always #10 clk = ~clk;

    voq_buffer #(.N_PORTS(N), .DEPTH(DEPTH), .CELL_W(CELL_W), .DROP_W(DROP_W)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_dest(in_dest), .in_eop(in_eop),
        .in_data(in_data), .inhibit(inhibit), .grant_valid(grant_valid),
        .grant_port(grant_port), .req(req), .out_valid(out_valid), .out_port(out_port),
        .out_eop(out_eop), .out_data(out_data), .grant_err(grant_err), .drop_cnt(drop_cnt)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // behavioural reference: one queue of {eop,data} per destination
    logic [CELL_W:0] mq [N][$];
    int occ = 0;
    int m_drop = 0;
    logic m_ov = 0, m_err = 0, m_eop = 0;
    int m_port = 0;
    logic [CELL_W-1:0] m_data = '0;

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] model_req();
        logic [N-1:0] r;
        for (int j = 0; j < N; j++) begin
            int e = 0;
            foreach (mq[j][k]) if (mq[j][k][CELL_W]) e++;
            r[j] = !inhibit[j] && (mq[j].size() >= 2 || e > 0);
        end
        return r;
    endfunction

    task automatic model_edge();
        int pre = occ;
        m_ov = 0; m_err = 0;
        if (grant_valid) begin
            if (int'(grant_port) < N && mq[grant_port].size() > 0 && !inhibit[grant_port]) begin
                logic [CELL_W:0] c = mq[grant_port].pop_front();
                m_ov = 1; m_port = int'(grant_port);
                m_eop = c[CELL_W]; m_data = c[CELL_W-1:0];
                occ--;
            end else m_err = 1;
        end
        if (in_valid) begin
            if (int'(in_dest) < N && pre < DEPTH) begin
                mq[in_dest].push_back({in_eop, in_data});
                occ++;
            end else if (m_drop < (1 << DROP_W) - 1) m_drop++;
        end
    endtask

    // one clock: req checked before the edge, registered outputs after it
    task automatic step();
        #1;
        chk("R3 req", req, model_req());
        @(posedge clk);
        model_edge();
        #2;
        chk("R4 out_valid", out_valid, m_ov);
        if (m_ov) begin
            chk("R4 out_port", out_port, m_port);
            chk("R2 out_data", out_data, m_data);
            chk("R2 out_eop", out_eop, m_eop);
        end
        chk("R5 grant_err", grant_err, m_err);
        chk("R7 drop_cnt", drop_cnt, m_drop);
        @(negedge clk);
    endtask

    task automatic drive(input logic v, input int d, input logic e, input int dat,
                         input logic g, input int gp);
        in_valid = v; in_dest = PW'(d); in_eop = e; in_data = CELL_W'(dat);
        grant_valid = g; grant_port = PW'(gp);
    endtask

    task automatic idle();
        drive(0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1; inhibit = '0; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); #2;
        chk("R1 req", req, 0);
        chk("R1 out_valid", out_valid, 0);
        chk("R1 grant_err", grant_err, 0);
        chk("R1 drop_cnt", drop_cnt, 0);
        @(negedge clk);

        // R3: pair rule and end-of-packet rule
        drive(1, 2, 0, 'h100, 0, 0); step();
        chk("R3 single cell no req", req[2], 0);
        drive(1, 2, 0, 'h101, 0, 0); step();
        drive(1, 2, 0, 'h102, 0, 0); step();
        drive(1, 5, 1, 'h500, 0, 0); step();
        idle(); #1;
        chk("R3 pair req", req[2], 1);
        chk("R3 eop req", req[5], 1);
        inhibit[2] = 1; #1;
        chk("R3 inhibit masks", req[2], 0);

        // R5 + R6: inhibited queue refused, other queue still served
        drive(0, 0, 0, 0, 1, 2); step();
        chk("R5 inhibited grant err", grant_err, 1);
        drive(0, 0, 0, 0, 1, 5); step();
        chk("R6 other queue served", out_valid, 1);
        chk("R6 served data", out_data, 'h500);
        drive(0, 0, 0, 0, 1, 7); step();
        chk("R5 empty grant err", grant_err, 1);
        drive(0, 0, 0, 0, 1, 15); step();
        chk("R5 out-of-range grant err", grant_err, 1);
        inhibit = '0;

        // R8: bad destination tag
        drive(1, 15, 0, 'hBAD, 0, 0); step();
        chk("R8 bad dest dropped", drop_cnt, 1);

        // R9: arrival and grant on same queue
        drive(1, 2, 1, 'h103, 1, 2); step();
        chk("R9 same-cycle pop order", out_data, 'h100);
        idle();
        for (int k = 0; k < 3; k++) begin drive(0, 0, 0, 0, 1, 2); step(); end
        chk("R2 last of chain eop", out_eop, 1);

        // R7: fill the pool
        for (int k = 0; k < DEPTH; k++) begin drive(1, 3, k[0], 'h300 + k, 0, 0); step(); end
        drive(1, 3, 0, 'hDEAD, 0, 0); step();
        chk("R7 full drop", drop_cnt, 2);
        drive(1, 4, 0, 'hBEEF, 1, 3); step();
        chk("R7 full drop with pop", drop_cnt, 3);
        drive(1, 4, 1, 'h400, 0, 0); step();
        chk("R9 freed slot reused", drop_cnt, 3);
        idle();
        for (int k = 0; k < DEPTH; k++) begin drive(0, 0, 0, 0, 1, (k % 2 == 0) ? 3 : 4); step(); end

        // mixed random traffic
        for (int k = 0; k < 3000; k++) begin
            if (k % 17 == 0) inhibit = N'($urandom);
            drive(($urandom % 3) != 0, $urandom % 16, ($urandom % 4) == 0, $urandom,
                  ($urandom % 2) == 0, $urandom % 16);
            step();
        end
        inhibit = '0;
        for (int j = 0; j < N; j++)
            while (mq[j].size() > 0) begin drive(0, 0, 0, 0, 1, j); step(); end
        idle(); step();
        chk("R2 drained", occ, 0);
        chk("R1 req idle after drain", req, 0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule